// File: doc/BRIEF.md
# Four-Channel DMA Channel Register File and Transfer Counter

This block holds the programming state of a four-channel DMA controller and advances it one transfer at a time. A byte-wide I/O port bus loads and reads back each channel's 16-bit address and count. These two registers are reached through a single shared byte-order flip-flop that alternates between the low and the high byte. The same bus writes the per-channel mode, the channel mask and a flip-flop clear, and reads the mask and a terminal-count status byte.

A per-channel request/acknowledge pair drives the counters. When a channel is unmasked, has a request and sees an acknowledge, its current address goes up by one and its current count goes down by one. A registered pulse reports each transfer, and a second pulse reports terminal count. When terminal count is reached, an auto-initializing channel reloads its base values; any other channel masks itself. A channel in cascade mode counts nothing. It only forwards its request and acknowledge to an external controller. Building the memory cycle and bus arbitration are left to the surrounding logic.

Port map (io_addr): 0x0–0x7 channel registers, where the channel is addr[2:1] and addr[0] selects address (0) or count (1). 0x8 reads status. 0x9 is the single-channel mask write. 0xA is the mode write. 0xB is the byte-order clear. 0xC writes and reads the whole mask.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four channels are masked (a read of port 0xC returns 0x0F), the status byte reads 0x00, and the byte-order flip-flop points at the low byte.
- R2: A channel's address or count is written and read as two consecutive byte accesses to its port, low byte first and then high byte. Each access toggles one flip-flop that all channel ports share.
- R3: Any write to port 0xB returns the byte-order flip-flop to the low byte, whatever data is written.
- R4: When dreq, dack_in and the unmask state of a non-cascade channel are all present in one cycle, that channel's current address increments by one and its current count decrements by one. xfer_pulse for the channel is high in the following cycle.
- R5: A channel that is masked, or that lacks either dreq or dack_in, keeps its address and count unchanged and gives no xfer_pulse.
- R6: A programmed count of N-1 yields N transfers. Terminal count happens on the transfer that finds the count at zero. tc_pulse goes high together with that transfer's xfer_pulse, and status bit c (bits 3:0 hold channels 0 to 3) is set.
- R7: A channel without auto-initialize that reaches terminal count sets its own mask bit, and its count reads 0xFFFF afterwards.
- R8: A channel with auto-initialize that reaches terminal count reloads its current address and count from the last programmed values and stays unmasked.
- R9: A read of port 0x8 returns the status bits, and the bits it returned are cleared afterwards.
- R10: A write to port 0x9 selects the channel with bits 1:0 and masks it when bit 2 is 1 or unmasks it when bit 2 is 0. The other channels are left as they were.
- R11: A write to port 0xC loads all four mask bits from bits 3:0 at once.
- R12: A channel whose mode field (bits 5:4) is 2'b10 (cascade) never changes its address or count and never pulses. hreq follows dreq while the channel is unmasked, and dack_out follows dack_in while the channel is unmasked.
- R13: A mode write takes the channel from bits 1:0, the direction from bit 2 (driven on xfer_dir), auto-initialize from bit 3 and the mode field from bits 5:4. The values 00 (demand) and 01 and 11 (single) count alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_cs | input | 1 | Port bus select |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte (valid while io_cs and io_rd) |
| dreq | input | 4 | Per-channel transfer request |
| dack_in | input | 4 | Per-channel transfer acknowledge |
| hreq | output | 4 | Request forwarded to the arbiter (unmasked channels) |
| dack_out | output | 4 | Acknowledge passed through for cascade channels |
| xfer_dir | output | 4 | Per-channel direction bit from the mode register |
| xfer_pulse | output | 4 | One-cycle pulse per completed transfer |
| tc_pulse | output | 4 | One-cycle pulse on terminal count |

## Verification
Some rules hold in every cycle, and the bound checker watches them. A transfer pulse needs a request and acknowledge on an unmasked channel in the previous cycle. A cascade channel that passed an acknowledge never pulses. Terminal count never pulses without a transfer. Status bits rise only together with terminal count. The byte-order flip-flop is at the low byte after a clear. Other behaviour shows only in the bench's scenarios: that N-1 really gives N transfers, the exact address and count values after terminal count with and without reload, the self-masking, the clear-on-read of status, and the effect of each mask port.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int unsigned N_CHAN = 4;
    localparam int unsigned CH_W   = $clog2(N_CHAN);
    localparam int unsigned PORT_W = 4;

    localparam logic [PORT_W-1:0] P_STATUS = 4'h8;
    localparam logic [PORT_W-1:0] P_SMASK  = 4'h9;
    localparam logic [PORT_W-1:0] P_MODE   = 4'hA;
    localparam logic [PORT_W-1:0] P_CLRFF  = 4'hB;
    localparam logic [PORT_W-1:0] P_AMASK  = 4'hC;

    typedef enum logic [1:0] {
        XM_DEMAND  = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_CASCADE = 2'b10,
        XM_SINGLE2 = 2'b11
    } xfer_mode_e;

    // Field order matches mode byte bits 5:2
    typedef struct packed {
        xfer_mode_e kind;
        logic       autoinit;
        logic       dir;
    } chan_mode_t;

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan #(
    parameter int unsigned DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_addr,
    input  logic            wr_cnt,
    input  logic            hi_sel,
    input  logic [DW-1:0]   wdata,
    input  logic            autoinit,
    input  logic            cascade,
    input  logic            masked,
    input  logic            dreq,
    input  logic            dack,
    output logic [2*DW-1:0] cur_addr,
    output logic [2*DW-1:0] cur_cnt,
    output logic            step,
    output logic            term
);
    localparam int unsigned RW = 2 * DW;

    typedef struct packed {
        logic [RW-1:0] base_addr;
        logic [RW-1:0] base_cnt;
        logic [RW-1:0] cur_addr;
        logic [RW-1:0] cur_cnt;
    } chan_st_t;

    chan_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        step = dreq & dack & ~masked & ~cascade;
        term = step & (s_q.cur_cnt == '0);

        if (step) begin
            if (term && autoinit) begin
                s_d.cur_addr = s_q.base_addr;
                s_d.cur_cnt  = s_q.base_cnt;
            end else begin
                s_d.cur_addr = s_q.cur_addr + RW'(1);
                s_d.cur_cnt  = s_q.cur_cnt - RW'(1);
            end
        end

        // A software write wins over a transfer for the register it touches
        if (wr_addr) begin
            if (hi_sel) begin
                s_d.base_addr[DW +: DW] = wdata;
                s_d.cur_addr[DW +: DW]  = wdata;
            end else begin
                s_d.base_addr[0 +: DW] = wdata;
                s_d.cur_addr[0 +: DW]  = wdata;
            end
        end
        if (wr_cnt) begin
            if (hi_sel) begin
                s_d.base_cnt[DW +: DW] = wdata;
                s_d.cur_cnt[DW +: DW]  = wdata;
            end else begin
                s_d.base_cnt[0 +: DW] = wdata;
                s_d.cur_cnt[0 +: DW]  = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_addr = s_q.cur_addr;
    assign cur_cnt  = s_q.cur_cnt;

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [PORT_W-1:0]       addr,
    input  logic [DW-1:0]           wdata,
    input  logic [N_CHAN-1:0]       term,
    output logic                    hi_sel,
    output logic [N_CHAN-1:0]       mask,
    output logic [N_CHAN-1:0]       status,
    output chan_mode_t [N_CHAN-1:0] modes
);
    typedef struct packed {
        logic                    hi;
        logic [N_CHAN-1:0]       mask;
        logic [N_CHAN-1:0]       status;
        chan_mode_t [N_CHAN-1:0] mode;
    } ctrl_st_t;

    ctrl_st_t r_d, r_q;
    logic     chan_port;
    logic     unused_hi_bits;

    assign unused_hi_bits = ^wdata[DW-1:6];

    always_comb begin
        r_d       = r_q;
        chan_port = ~addr[PORT_W-1];

        if (wr_en && addr == P_CLRFF)
            r_d.hi = 1'b0;
        else if ((wr_en || rd_en) && chan_port)
            r_d.hi = ~r_q.hi;

        if (wr_en && addr == P_SMASK)
            r_d.mask[wdata[CH_W-1:0]] = wdata[2];
        if (wr_en && addr == P_AMASK)
            r_d.mask = wdata[N_CHAN-1:0];
        if (wr_en && addr == P_MODE)
            r_d.mode[wdata[CH_W-1:0]] = chan_mode_t'(wdata[5:2]);

        for (int i = 0; i < N_CHAN; i++) begin
            if (term[i] && !r_q.mode[i].autoinit)
                r_d.mask[i] = 1'b1;
        end

        if (rd_en && addr == P_STATUS)
            r_d.status = term;
        else
            r_d.status = r_q.status | term;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mask <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign hi_sel = r_q.hi;
    assign mask   = r_q.mask;
    assign status = r_q.status;
    assign modes  = r_q.mode;

endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_cs,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [PORT_W-1:0]   io_addr,
    input  logic [DW-1:0]       io_wdata,
    output logic [DW-1:0]       io_rdata,
    input  logic [N_CHAN-1:0]   dreq,
    input  logic [N_CHAN-1:0]   dack_in,
    output logic [N_CHAN-1:0]   hreq,
    output logic [N_CHAN-1:0]   dack_out,
    output logic [N_CHAN-1:0]   xfer_dir,
    output logic [N_CHAN-1:0]   xfer_pulse,
    output logic [N_CHAN-1:0]   tc_pulse
);
    localparam int unsigned RW = 2 * DW;

    typedef struct packed {
        logic [N_CHAN-1:0] xfer;
        logic [N_CHAN-1:0] tc;
    } pulse_t;

    logic                    wr_en, rd_en;
    logic                    byte_hi;
    logic [N_CHAN-1:0]       mask_vec, status_vec, step_vec, term_vec, casc_vec;
    chan_mode_t [N_CHAN-1:0] modes;
    logic [RW-1:0]           addr_w [N_CHAN];
    logic [RW-1:0]           cnt_w  [N_CHAN];
    logic [RW-1:0]           rd_word;
    pulse_t                  p_d, p_q;

    assign wr_en = io_cs & io_wr;
    assign rd_en = io_cs & io_rd;

    dmac_ctrl #(.DW(DW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (io_addr),
        .wdata  (io_wdata),
        .term   (term_vec),
        .hi_sel (byte_hi),
        .mask   (mask_vec),
        .status (status_vec),
        .modes  (modes)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        logic sel;
        assign sel         = wr_en & ~io_addr[PORT_W-1] & (io_addr[CH_W:1] == CH_W'(g));
        assign casc_vec[g] = (modes[g].kind == XM_CASCADE);
        assign xfer_dir[g] = modes[g].dir;

        dmac_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_addr  (sel & ~io_addr[0]),
            .wr_cnt   (sel & io_addr[0]),
            .hi_sel   (byte_hi),
            .wdata    (io_wdata),
            .autoinit (modes[g].autoinit),
            .cascade  (casc_vec[g]),
            .masked   (mask_vec[g]),
            .dreq     (dreq[g]),
            .dack     (dack_in[g]),
            .cur_addr (addr_w[g]),
            .cur_cnt  (cnt_w[g]),
            .step     (step_vec[g]),
            .term     (term_vec[g])
        );
    end

    assign hreq     = dreq & ~mask_vec;
    assign dack_out = dack_in & casc_vec & ~mask_vec;

    always_comb begin
        rd_word  = io_addr[0] ? cnt_w[io_addr[CH_W:1]] : addr_w[io_addr[CH_W:1]];
        io_rdata = '0;
        if (rd_en) begin
            if (!io_addr[PORT_W-1])
                io_rdata = byte_hi ? rd_word[RW-1:DW] : rd_word[DW-1:0];
            else if (io_addr == P_STATUS)
                io_rdata = DW'(status_vec);
            else if (io_addr == P_AMASK)
                io_rdata = DW'(mask_vec);
        end
    end

    always_comb begin
        p_d.xfer = step_vec;
        p_d.tc   = term_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign xfer_pulse = p_q.xfer;
    assign tc_pulse   = p_q.tc;

endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk
    import dmac_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                io_cs,
    input logic                io_wr,
    input logic [PORT_W-1:0]   io_addr,
    input logic [N_CHAN-1:0]   dreq,
    input logic [N_CHAN-1:0]   dack_in,
    input logic [N_CHAN-1:0]   hreq,
    input logic [N_CHAN-1:0]   dack_out,
    input logic [N_CHAN-1:0]   xfer_pulse,
    input logic [N_CHAN-1:0]   tc_pulse,
    input logic [N_CHAN-1:0]   status_vec,
    input logic                byte_hi
);
    p_pulse_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pulse & ~$past(dreq & dack_in)) == '0);

    p_masked_no_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pulse & ~$past(hreq)) == '0);

    p_tc_with_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse & ~xfer_pulse) == '0);

    p_status_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec & ~$past(status_vec) & ~tc_pulse) == '0);

    p_cascade_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pulse & $past(dack_out)) == '0);

    p_clrff_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(io_cs && io_wr && io_addr == P_CLRFF) |-> !byte_hi);

endmodule

bind dmac_regfile dmac_regfile_chk u_chk (.*);

// File: tb/tb_dmac_regfile.sv
module tb_dmac_regfile;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_cs = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [3:0] dreq = '0, dack_in = '0;
    logic [3:0] hreq, dack_out, xfer_dir, xfer_pulse, tc_pulse;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    dmac_regfile dut (
        .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dreq(dreq), .dack_in(dack_in), .hreq(hreq), .dack_out(dack_out),
        .xfer_dir(xfer_dir), .xfer_pulse(xfer_pulse), .tc_pulse(tc_pulse)
    );

    // {read, port, write data, expected read data}
    localparam int NV = 26;
    localparam logic [20:0] VECS [NV] = '{
        {1'b1, 4'hC, 8'h00, 8'h0F},   // R1 all masked
        {1'b1, 4'h8, 8'h00, 8'h00},   // R1 status empty
        {1'b0, 4'h0, 8'h34, 8'h00},   // R2 ch0 address low
        {1'b0, 4'h0, 8'h12, 8'h00},   // R2 ch0 address high
        {1'b1, 4'h0, 8'h00, 8'h34},
        {1'b1, 4'h0, 8'h00, 8'h12},
        {1'b0, 4'h1, 8'h02, 8'h00},   // R2 ch0 count = 3 transfers
        {1'b0, 4'h1, 8'h00, 8'h00},
        {1'b1, 4'h1, 8'h00, 8'h02},
        {1'b1, 4'h1, 8'h00, 8'h00},
        {1'b0, 4'h2, 8'hAA, 8'h00},   // R3 leaves flip-flop high
        {1'b0, 4'hB, 8'h5A, 8'h00},   // R3 clear
        {1'b0, 4'h2, 8'hCD, 8'h00},
        {1'b0, 4'h2, 8'hAB, 8'h00},
        {1'b1, 4'h2, 8'h00, 8'hCD},
        {1'b1, 4'h2, 8'h00, 8'hAB},
        {1'b0, 4'h9, 8'h00, 8'h00},   // R10 unmask ch0
        {1'b1, 4'hC, 8'h00, 8'h0E},
        {1'b0, 4'h9, 8'h01, 8'h00},   // R10 unmask ch1
        {1'b1, 4'hC, 8'h00, 8'h0C},
        {1'b0, 4'h9, 8'h05, 8'h00},   // R10 mask ch1
        {1'b1, 4'hC, 8'h00, 8'h0E},
        {1'b0, 4'hC, 8'h05, 8'h00},   // R11 whole mask
        {1'b1, 4'hC, 8'h00, 8'h05},
        {1'b0, 4'hC, 8'h0E, 8'h00},
        {1'b1, 4'hC, 8'h00, 8'h0E}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_cs = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk);
        #1 io_cs = 1'b0; io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        io_cs = 1'b1; io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        @(posedge clk);
        #1 io_cs = 1'b0; io_rd = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] w);
        logic [7:0] lo, hi;
        bus_rd(a, lo);
        bus_rd(a, hi);
        w = {hi, lo};
    endtask

    task automatic xfer(input int ch, input logic rq, input logic ak,
                        output logic xp, output logic tp);
        @(negedge clk);
        dreq[ch] = rq; dack_in[ch] = ak;
        @(posedge clk);
        #1 xp = xfer_pulse[ch]; tp = tc_pulse[ch];
        dreq = '0; dack_in = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        logic        xp, tp;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][20]) begin
                bus_rd(VECS[i][19:16], b);
                chk($sformatf("R1/R2/R3/R10/R11 vector %0d", i), {8'h0, b}, {8'h0, VECS[i][7:0]});
            end else begin
                bus_wr(VECS[i][19:16], VECS[i][15:8]);
            end
        end

        // R13: ch0 write direction, single, no reload
        bus_wr(4'hA, 8'h14);
        #1 chk("R13 dir ch0", {15'h0, xfer_dir[0]}, 16'h1);

        // R5: request without acknowledge
        xfer(0, 1'b1, 1'b0, xp, tp);
        chk("R5 no ack", {15'h0, xp}, 16'h0);
        // R5: masked ch2 with both strobes
        @(negedge clk);
        dreq[2] = 1'b1; dack_in[2] = 1'b1;
        #1 chk("R5 hreq masked", {15'h0, hreq[2]}, 16'h0);
        @(posedge clk);
        #1 chk("R5 masked pulse", {15'h0, xfer_pulse[2]}, 16'h0);
        dreq = '0; dack_in = '0;

        // R4: one transfer
        xfer(0, 1'b1, 1'b1, xp, tp);
        chk("R4 pulse", {14'h0, xp, tp}, 16'h2);
        rd16(4'h0, w); chk("R4 addr+1", w, 16'h1235);
        rd16(4'h1, w); chk("R4 count-1", w, 16'h0001);

        // R6: N-1 = 2 gives three transfers, last one terminal
        xfer(0, 1'b1, 1'b1, xp, tp);
        chk("R6 second", {14'h0, xp, tp}, 16'h2);
        xfer(0, 1'b1, 1'b1, xp, tp);
        chk("R6 third tc", {14'h0, xp, tp}, 16'h3);
        rd16(4'h1, w); chk("R7 count wraps", w, 16'hFFFF);
        rd16(4'h0, w); chk("R7 addr", w, 16'h1237);
        bus_rd(4'hC, b); chk("R7 self mask", {8'h0, b}, 16'h000F);
        bus_rd(4'h8, b); chk("R9 status", {8'h0, b}, 16'h0001);
        bus_rd(4'h8, b); chk("R9 cleared", {8'h0, b}, 16'h0000);
        xfer(0, 1'b1, 1'b1, xp, tp);
        chk("R5 after tc masked", {15'h0, xp}, 16'h0);
        rd16(4'h0, w); chk("R5 addr held", w, 16'h1237);

        // R8: ch1 auto-initialize, two transfers
        bus_wr(4'h3, 8'h01);
        bus_wr(4'h3, 8'h00);
        bus_wr(4'hA, 8'h19);
        #1 chk("R13 dir ch1", {15'h0, xfer_dir[1]}, 16'h0);
        bus_wr(4'h9, 8'h01);
        xfer(1, 1'b1, 1'b1, xp, tp);
        chk("R8 first", {14'h0, xp, tp}, 16'h2);
        xfer(1, 1'b1, 1'b1, xp, tp);
        chk("R8 tc", {14'h0, xp, tp}, 16'h3);
        rd16(4'h2, w); chk("R8 addr reload", w, 16'hABCD);
        rd16(4'h3, w); chk("R8 count reload", w, 16'h0001);
        bus_rd(4'hC, b); chk("R8 stays unmasked", {8'h0, b}, 16'h000D);
        bus_rd(4'h8, b); chk("R9 status ch1", {8'h0, b}, 16'h0002);

        // R12: ch3 cascade
        bus_wr(4'h7, 8'h05);
        bus_wr(4'h7, 8'h00);
        bus_wr(4'hA, 8'h23);
        bus_wr(4'h9, 8'h03);
        @(negedge clk);
        dreq[3] = 1'b1; dack_in[3] = 1'b1; dack_in[1] = 1'b1;
        #1 chk("R12 hreq", {12'h0, hreq}, 16'h0008);
        chk("R12 dack_out", {12'h0, dack_out}, 16'h0008);
        @(posedge clk);
        #1 chk("R12 no pulse", {12'h0, xfer_pulse}, 16'h0000);
        dreq = '0; dack_in = '0;
        rd16(4'h7, w); chk("R12 count held", w, 16'h0005);

        // R1: reset mid-sequence with the flip-flop left high
        bus_wr(4'h4, 8'h11);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        bus_rd(4'hC, b); chk("R1 masked after reset", {8'h0, b}, 16'h000F);
        bus_rd(4'h8, b); chk("R1 status after reset", {8'h0, b}, 16'h0000);
        bus_wr(4'h0, 8'h77);
        bus_wr(4'h0, 8'h66);
        rd16(4'h0, w); chk("R1 flip-flop low after reset", w, 16'h6677);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule